// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block connects the load/store path of a small in-order integer core to a data memory that is 32 bits wide and addressed by word. For a memory operation it adds the base register value to the sign-extended 12-bit offset to form the effective address. It sends the memory the word address of that location. For a store, it steers the byte, halfword or word of the source register into the lanes that the two low address bits select, together with a matching write strobe. For a load, it waits for the memory to signal valid data, picks the addressed byte, halfword or word out of the returned word, and sign- or zero-extends it to 32 bits. The extended value is then presented to the register file one cycle later.

Accesses that do not fall on their natural boundary are refused: they raise a misaligned flag and never reach the memory. Stores complete in the cycle they are accepted. A load keeps the block busy until its write-back cycle, and new requests are ignored during that time. A load whose destination is register 0 runs on the memory but writes nothing back.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended from 12 bits. While `mem_req` is high, `mem_addr` carries that address with bits [1:0] forced to 0.
- R2: A byte store (`req_size`=2'b00) drives `mem_wstrb` = 4'b0001 shifted left by address bits [1:0], and drives `mem_wdata` = the low byte of `req_wdata` copied into all four lanes.
- R3: A halfword store (`req_size`=2'b01) at an even address drives `mem_wstrb` = 4'b0011 shifted left by 2×address bit 1, and drives `mem_wdata` = the low halfword of `req_wdata` copied into both halves.
- R4: A word store (`req_size`=2'b10; 2'b11 behaves the same) at a word-aligned address drives `mem_wstrb`=4'b1111 and `mem_wdata`=`req_wdata`.
- R5: An accepted request is misaligned when it is a halfword with address bit 0 set, or a word with address bits [1:0] not zero. In that case `misaligned` is 1 in the same cycle, `mem_req` stays 0, the block does not become busy, and no register write follows.
- R6: The signed loads (`req_unsigned`=0) take the byte at lane address[1:0], or the halfword at lane 2×address[1], and copy its top bit into all upper bits of `rd_data`.
- R7: The unsigned byte and halfword loads (`req_unsigned`=1) fill the upper bits of `rd_data` with zeros. A word load returns the memory word unchanged.
- R8: Memory store requests assert `mem_we`=1 and load requests assert `mem_we`=0, with `mem_wstrb`=0 on loads.
- R9: Load data is captured on the clock edge at which `mem_rvalid` is high while the load waits. `rd_we`, `rd_idx` and `rd_data` are valid during the next cycle, and `busy` is high from the cycle after acceptance through that write-back cycle.
- R10: A load whose `req_rd` is 0 never asserts `rd_we`.
- R11: After reset, `busy`, `rd_we`, `mem_req` and `misaligned` are all 0.
- R12: While `busy` is high, `req_valid` is ignored: no `mem_req` and no `misaligned`. `mem_rvalid` is ignored while no load is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Memory operation offered this cycle |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend a load result |
| req_base | input | 32 | Base register value |
| req_imm | input | 12 | Signed address offset |
| req_wdata | input | 32 | Store source register value |
| req_rd | input | 5 | Load destination register index |
| busy | output | 1 | Load in flight; requests are ignored |
| misaligned | output | 1 | Accepted request refused for alignment |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read word |
| rd_we | output | 1 | Register write enable |
| rd_idx | output | 5 | Register write index |
| rd_data | output | 32 | Extended load result |

## Verification
The hardest situations to reach are those that meet a load while it is outstanding. These are a second request offered during the wait, a valid pulse arriving when no load is pending, and a memory latency long enough that `busy` must hold over several cycles. The bench models the memory itself. It returns data after a latency of one to three cycles chosen per load, offers a store in the middle of a wait, and pulses valid while the block is idle. All of this runs inside a sweep over every size, signedness, lane offset and boundary offset value, so that each of these conditions is met from many starting states.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_WB   = 2'd2
    } lsu_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    // Number of bytes touched by an access, capped at the bus width in lanes.
    function automatic int unsigned acc_bytes(input logic [1:0] size, input int unsigned lanes);
        int unsigned n;
        n = 1 << size;
        if (n > lanes) n = lanes;
        return n;
    endfunction

    // Offset not a multiple of the access size.
    function automatic logic is_unaligned(input logic [1:0] size, input int unsigned lane,
                                          input int unsigned lanes);
        int unsigned n;
        n = acc_bytes(size, lanes);
        return (lane % n) != 0;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    localparam int LANES   = XLEN / 8,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic [XLEN-1:0]    base,
    input  logic [IMM_W-1:0]   imm,
    input  logic [1:0]         size,
    output logic [XLEN-1:0]    word_addr,
    output logic [LANE_AW-1:0] lane,
    output logic               unaligned
);
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] eff;

    assign imm_sx    = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign eff       = base + imm_sx;
    assign lane      = eff[LANE_AW-1:0];
    assign word_addr = {eff[XLEN-1:LANE_AW], {LANE_AW{1'b0}}};

    always_comb begin
        unaligned = is_unaligned(size, int'(unsigned'(lane)), LANES);
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int LANES   = XLEN / 8,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic [XLEN-1:0]    src,
    input  logic [1:0]         size,
    input  logic [LANE_AW-1:0] lane,
    output logic [XLEN-1:0]    data,
    output logic [LANES-1:0]   strobe
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            int unsigned n;
            int unsigned lo;
            n  = acc_bytes(size, LANES);
            lo = int'(unsigned'(lane));
            // byte of the source that lands in lane i: repeats every n lanes
            data[8*i +: 8] = src[8*(i % n) +: 8];
            strobe[i]      = (i >= lo) && (i < lo + n);
        end
    end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int LANES   = XLEN / 8,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic [XLEN-1:0]    word,
    input  logic [1:0]         size,
    input  logic               uns,
    input  logic [LANE_AW-1:0] lane,
    output logic [XLEN-1:0]    result
);
    logic [XLEN-1:0] shifted;
    logic            fill;

    always_comb begin
        int unsigned n;
        n       = acc_bytes(size, LANES);
        shifted = word >> (8 * int'(unsigned'(lane)));
        fill    = !uns && shifted[8*n - 1];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        always_comb begin
            if (k < acc_bytes(size, LANES)) result[8*k +: 8] = shifted[8*k +: 8];
            else                            result[8*k +: 8] = {8{fill}};
        end
    end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    parameter int RAW   = 5,
    localparam int LANES   = XLEN / 8,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [XLEN-1:0]   req_base,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic [RAW-1:0]    req_rd,
    output logic              busy,
    output logic              misaligned,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [LANES-1:0]  mem_wstrb,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rd_we,
    output logic [RAW-1:0]    rd_idx,
    output logic [XLEN-1:0]   rd_data
);
    typedef struct packed {
        logic [1:0]         size;
        logic               uns;
        logic [LANE_AW-1:0] lane;
        logic [RAW-1:0]     rd;
    } ld_ctx_t;

    lsu_state_e         state_q, state_d;
    ld_ctx_t            ctx_q;
    logic [XLEN-1:0]    rd_data_q;

    logic [XLEN-1:0]    word_addr;
    logic [LANE_AW-1:0] lane;
    logic               unaligned;
    logic [XLEN-1:0]    st_data;
    logic [LANES-1:0]   st_strb;
    logic [XLEN-1:0]    ld_ext;
    logic               accept;
    logic               issue;

    lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
        .base      (req_base),
        .imm       (req_imm),
        .size      (req_size),
        .word_addr (word_addr),
        .lane      (lane),
        .unaligned (unaligned)
    );

    lsu_store_lane #(.XLEN(XLEN)) u_store (
        .src    (req_wdata),
        .size   (req_size),
        .lane   (lane),
        .data   (st_data),
        .strobe (st_strb)
    );

    lsu_load_extend #(.XLEN(XLEN)) u_load (
        .word   (mem_rdata),
        .size   (ctx_q.size),
        .uns    (ctx_q.uns),
        .lane   (ctx_q.lane),
        .result (ld_ext)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign issue  = accept && !unaligned;

    assign busy       = (state_q != ST_IDLE);
    assign misaligned = accept && unaligned;
    assign mem_req    = issue;
    assign mem_we     = issue && req_is_store;
    assign mem_addr   = word_addr;
    assign mem_wstrb  = (issue && req_is_store) ? st_strb : '0;
    assign mem_wdata  = st_data;

    assign rd_we   = (state_q == ST_WB) && (ctx_q.rd != '0);
    assign rd_idx  = ctx_q.rd;
    assign rd_data = rd_data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue && !req_is_store) state_d = ST_WAIT;
            ST_WAIT: if (mem_rvalid)             state_d = ST_WB;
            ST_WB:                               state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            rd_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (issue && !req_is_store) begin
                ctx_q.size <= req_size;
                ctx_q.uns  <= req_unsigned;
                ctx_q.lane <= lane;
                ctx_q.rd   <= req_rd;
            end
            if (state_q == ST_WAIT && mem_rvalid) begin
                rd_data_q <= ld_ext;
            end
        end
    end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
    parameter int XLEN  = 32,
    parameter int RAW   = 5,
    localparam int LANES = XLEN / 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_is_store,
    input logic [1:0]       req_size,
    input logic             busy,
    input logic             misaligned,
    input logic             mem_req,
    input logic             mem_we,
    input logic [XLEN-1:0]  mem_addr,
    input logic [LANES-1:0] mem_wstrb,
    input logic             mem_rvalid,
    input logic             rd_we,
    input logic [RAW-1:0]   rd_idx
);
    // R1
    a_r1_word_addr: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R2
    a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
        (mem_we && req_size == 2'b00) |-> ($countones(mem_wstrb) == 1));

    // R4
    a_r4_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (mem_we && req_size[1]) |-> (mem_wstrb == '1));

    // R5
    a_r5_refused_not_issued: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (!mem_req && !mem_we));

    a_r5_refused_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (misaligned && !busy) |=> !busy);

    // R8
    a_r8_load_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_wstrb == '0));

    // R9
    a_r9_wb_after_valid: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> ($past(mem_rvalid && busy) && busy));

    // R10
    a_r10_no_reg0_write: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> (rd_idx != '0));

    // R11
    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !rd_we));

    // R12
    a_r12_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!mem_req && !misaligned));

    a_r12_store_not_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_req && req_is_store && req_valid) |=> !busy);
endmodule

bind lsu_align lsu_align_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_size     (req_size),
    .busy         (busy),
    .misaligned   (misaligned),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wstrb    (mem_wstrb),
    .mem_rvalid   (mem_rvalid),
    .rd_we        (rd_we),
    .rd_idx       (rd_idx)
);

// File: tb/lsu_align_tb.sv
module lsu_align_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [11:0] req_imm = '0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  req_rd = '0;
    logic        busy, misaligned, mem_req, mem_we, rd_we;
    logic [31:0] mem_addr, mem_wdata, rd_data;
    logic [3:0]  mem_wstrb;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rd_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsu_align u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_imm(req_imm), .req_wdata(req_wdata), .req_rd(req_rd), .busy(busy),
        .misaligned(misaligned), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rd_we(rd_we),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] w, input int ln,
                                             input logic [1:0] sz, input bit uns);
        logic [31:0] v;
        int n;
        n = nbytes(sz);
        v = w >> (8 * ln);
        if (n == 1) begin
            v = v & 32'h0000_00FF;
            if (!uns && v >= 32'h80) v = v | 32'hFFFF_FF00;
        end else if (n == 2) begin
            v = v & 32'h0000_FFFF;
            if (!uns && v >= 32'h8000) v = v | 32'hFFFF_0000;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'b00) return {4{d[7:0]}};
        if (sz == 2'b01) return {2{d[15:0]}};
        return d;
    endfunction

    // drive a request at a falling edge; checks are taken after settling
    task automatic offer(input bit st, input logic [1:0] sz, input bit uns,
                         input logic [31:0] b, input logic [11:0] im,
                         input logic [31:0] wd, input logic [4:0] rd);
        req_valid = 1'b1; req_is_store = st; req_size = sz; req_unsigned = uns;
        req_base = b; req_imm = im; req_wdata = wd; req_rd = rd;
        #1;
    endtask

    task automatic do_store(input logic [1:0] sz, input logic [31:0] b,
                            input logic [11:0] im, input logic [31:0] wd);
        logic [31:0] ea;
        int ln, n;
        bit mis;
        @(negedge clk);
        offer(1'b1, sz, 1'b0, b, im, wd, 5'd0);
        ea  = b + {{20{im[11]}}, im};
        ln  = int'(ea[1:0]);
        n   = nbytes(sz);
        mis = (ln % n) != 0;
        chk(misaligned == mis, "R5 store misaligned flag", {31'b0, misaligned}, {31'b0, mis});
        if (mis) begin
            chk(mem_req == 1'b0 && mem_wstrb == 4'b0, "R5 refused store no access",
                {27'b0, mem_wstrb, mem_req}, 32'h0);
        end else begin
            chk(mem_req && mem_we, "R8 store request", {30'b0, mem_req, mem_we}, 32'h3);
            chk(mem_addr == {ea[31:2], 2'b00}, "R1 store address", mem_addr, {ea[31:2], 2'b00});
            chk(mem_wstrb == 4'(((1 << n) - 1) << ln),
                (n == 1) ? "R2 byte strobe" : (n == 2) ? "R3 half strobe" : "R4 word strobe",
                {28'b0, mem_wstrb}, 32'(((1 << n) - 1) << ln));
            chk(mem_wdata == exp_wdata(wd, sz),
                (n == 1) ? "R2 byte data" : (n == 2) ? "R3 half data" : "R4 word data",
                mem_wdata, exp_wdata(wd, sz));
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b0, "R12 store leaves block idle", {31'b0, busy}, 32'h0);
    endtask

    task automatic do_load(input logic [1:0] sz, input bit uns, input logic [31:0] b,
                           input logic [11:0] im, input logic [4:0] rd,
                           input logic [31:0] word, input int lat, input bit poke);
        logic [31:0] ea, e;
        int ln, n;
        bit mis;
        @(negedge clk);
        offer(1'b0, sz, uns, b, im, 32'hDEAD_BEEF, rd);
        ea  = b + {{20{im[11]}}, im};
        ln  = int'(ea[1:0]);
        n   = nbytes(sz);
        mis = (ln % n) != 0;
        chk(misaligned == mis, "R5 load misaligned flag", {31'b0, misaligned}, {31'b0, mis});
        if (mis) begin
            chk(mem_req == 1'b0, "R5 refused load no access", {31'b0, mem_req}, 32'h0);
            @(posedge clk); #1;
            req_valid = 1'b0;
            chk(busy == 1'b0 && rd_we == 1'b0, "R5 refused load no write-back",
                {30'b0, busy, rd_we}, 32'h0);
            return;
        end
        chk(mem_req && !mem_we && mem_wstrb == 4'b0, "R8 load request",
            {27'b0, mem_wstrb, mem_we}, 32'h0);
        chk(mem_addr == {ea[31:2], 2'b00}, "R1 load address", mem_addr, {ea[31:2], 2'b00});
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int c = 1; c < lat; c++) begin
            @(negedge clk);
            if (poke) begin
                offer(1'b1, 2'b10, 1'b0, 32'h40, 12'h0, 32'h1234_5678, 5'd3);
                chk(mem_req == 1'b0 && misaligned == 1'b0, "R12 request ignored while busy",
                    {30'b0, mem_req, misaligned}, 32'h0);
                req_valid = 1'b0;
            end
            chk(busy == 1'b1 && rd_we == 1'b0, "R9 busy while waiting", {30'b0, busy, rd_we}, 32'h2);
        end
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = word;
        @(posedge clk); #1;
        mem_rvalid = 1'b0; mem_rdata = 32'h5A5A_5A5A;
        e = exp_load(word, ln, sz, uns);
        chk(rd_we == (rd != 5'd0), (rd == 5'd0) ? "R10 register 0 not written" : "R9 write-back cycle",
            {31'b0, rd_we}, {31'b0, rd != 5'd0});
        chk(busy == 1'b1, "R9 busy in write-back", {31'b0, busy}, 32'h1);
        if (rd != 5'd0) begin
            chk(rd_idx == rd, "R9 write-back index", {27'b0, rd_idx}, {27'b0, rd});
            chk(rd_data == e, (n == 4) ? "R7 word load" : uns ? "R7 zero extend" : "R6 sign extend",
                rd_data, e);
        end
        @(posedge clk); #1;
        chk(busy == 1'b0 && rd_we == 1'b0, "R9 one write-back cycle only", {30'b0, busy, rd_we}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [11:0] imms [4];
        logic [31:0] words [4];
        logic [31:0] b;
        imms[0] = 12'h004; imms[1] = 12'hFF8; imms[2] = 12'h7FF; imms[3] = 12'h800;
        words[0] = 32'h8F7E_6D5C; words[1] = 32'h0180_FF7F;
        words[2] = 32'hFFFF_0000; words[3] = 32'h7F80_80FF;

        repeat (3) @(posedge clk);
        #1;
        // R11
        chk(busy == 1'b0 && rd_we == 1'b0 && mem_req == 1'b0 && misaligned == 1'b0,
            "R11 reset state", {28'b0, busy, rd_we, mem_req, misaligned}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(busy == 1'b0 && rd_we == 1'b0, "R11 idle after reset", {30'b0, busy, rd_we}, 32'h0);

        // stray valid while idle must not write back (R12)
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        mem_rvalid = 1'b0;
        @(posedge clk); #1;
        chk(rd_we == 1'b0 && busy == 1'b0, "R12 stray valid ignored", {30'b0, rd_we, busy}, 32'h0);

        // sweep: every size code, lane offset and offset extreme
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 4; off++) begin
                for (int p = 0; p < 4; p++) begin
                    b = 32'h2000_0000 + 32'(off) - {{20{imms[p][11]}}, imms[p]};
                    do_store(2'(sz), b, imms[p], words[p] ^ 32'(off * 32'h0101_0101));
                    for (int u = 0; u < 2; u++) begin
                        do_load(2'(sz), u[0], b, imms[p], 5'((p * 8 + off * 2 + u) % 32),
                                words[(p + off) % 4], 1 + ((p + u + off) % 3), (p == 1));
                    end
                end
            end
        end

        // R10: destination register 0 with long wait
        do_load(2'b10, 1'b0, 32'h100, 12'h0, 5'd0, 32'hCAFE_F00D, 3, 1'b1);
        // R6 boundary: 0x80 byte and 0x8000 halfword in top lanes
        do_load(2'b00, 1'b0, 32'h103, 12'h0, 5'd7, 32'h8000_0000, 1, 1'b0);
        do_load(2'b01, 1'b0, 32'h102, 12'h0, 5'd9, 32'h8000_7FFF, 2, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule